// File: doc/BRIEF.md
# Function Power-State Control Register

This block is the 16-bit power-management control and status register of one peripheral function. Software reaches it through a plain configuration write port with two byte lanes. The block holds a two-bit device power state, a wake-enable bit and a sticky wake-status bit. The register's full value is always present on a read bus.

The block derives three things from the power state. A gate holds the function's interrupt low outside full power. A memory-decode enable drops outside full power. A one-cycle warm-reset pulse fires when software moves the function from the off state back to full power. Configuration writes are always accepted, whatever the power state.

An external wake event sets the status bit. The wake output is raised only while both the enable bit and the status bit are set. The two wake bits sit in an always-on reset domain. The main reset and the warm-reset pulse leave them alone.

Top module: `fn_pwr_ctl`

## Requirements
- R1: After both resets are applied, the register reads 16'h0000, memory decode is enabled, and the warm-reset pulse and wake output are low.
- R2: A write with byte enable 0 set and a power-state value (bits 1:0) of 2'b00 (full power) or 2'b11 (off) loads that value. The new value reads back from the clock edge that takes the write.
- R3: A write of 2'b01 or 2'b10 to the power-state field completes, but it leaves the stored state unchanged.
- R4: Byte lanes are independent. A write with only byte enable 1 set never changes bits 1:0. A write with only byte enable 0 set never changes bits 15 and 8.
- R5: While the power state is not 2'b00, the interrupt output is 0. In state 2'b00 it follows the interrupt request input.
- R6: Memory decode enable is 1 in state 2'b00 and 0 in any other state.
- R7: An accepted write that changes the state from 2'b11 to 2'b00 raises the warm-reset output for exactly the one cycle after the write edge, and the state then reads 2'b00. A write of 2'b00 while already in 2'b00 gives no pulse.
- R8: Bit 15 (wake status) is set by a wake event whatever the state of bit 8. A write of 1 to bit 15 with byte enable 1 clears it, and a write of 0 leaves it unchanged.
- R9: If a wake event and a write-1-to-clear of bit 15 fall in the same cycle, bit 15 stays set.
- R10: The wake output is high exactly when bit 8 (wake enable, read/write through byte enable 1) and bit 15 are both 1.
- R11: Bits 14:9 and 7:2 always read 0, whatever is written to them.
- R12: The main reset clears the power state but keeps bits 15 and 8. The always-on reset clears bits 15 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_main_n | input | 1 | Main reset, asynchronous, active low |
| rst_aon_n | input | 1 | Always-on reset, asynchronous, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| cfg_wdata | input | 16 | Write data |
| reg_value | output | 16 | Current register value |
| wake_evt | input | 1 | Wake event; sets the status bit |
| irq_req | input | 1 | Interrupt request from the function |
| irq_out | output | 1 | Interrupt after power-state gating |
| mem_dec_en | output | 1 | Memory-space decode enable |
| pme_out | output | 1 | Internal wake output |
| warm_rst | output | 1 | One-cycle warm-reset pulse |

## Verification
The power-state field is driven with every two-bit code, through the low lane, the high lane and both lanes. This separates an accepted transition from a discarded code and from a write on the wrong lane. Warm-reset transitions from off and from full power are both tried, so a pulse that comes from any write to 00 can be told apart from one tied to leaving the off state. Wake events arrive alone, together with a clear, and before and after an enable. This isolates the sticky set, the write-1-to-clear and their priority. The two resets are applied separately with the wake bits set, so a status bit placed in the wrong reset domain is caught.

// File: rtl/fn_pwr_pkg.sv
package fn_pwr_pkg;
    localparam int REG_W   = 16;
    localparam int LANE_W  = 8;
    localparam int LANES   = REG_W / LANE_W;
    localparam int PS_W    = 2;
    localparam int PS_LSB  = 0;
    localparam int EN_BIT  = 8;
    localparam int STS_BIT = 15;

    localparam logic [PS_W-1:0] PS_FULL = 2'b00;
    localparam logic [PS_W-1:0] PS_OFF  = 2'b11;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            warm;
    } ps_regs_t;

    typedef struct packed {
        logic en;
        logic sts;
    } wake_regs_t;
endpackage

// File: rtl/fn_pwr_state.sv
module fn_pwr_state
    import fn_pwr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lane,
    input  logic [PS_W-1:0] wr_ps,
    output logic [PS_W-1:0] ps,
    output logic            warm_rst
);
    ps_regs_t cur_q, nxt_d;

    // Only the two defined codes are stored; the warm pulse lasts one cycle.
    always_comb begin
        nxt_d      = cur_q;
        nxt_d.warm = 1'b0;
        if (wr_lane && (wr_ps == PS_FULL || wr_ps == PS_OFF)) begin
            nxt_d.ps   = wr_ps;
            nxt_d.warm = (cur_q.ps == PS_OFF) && (wr_ps == PS_FULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{ps: PS_FULL, warm: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ps       = cur_q.ps;
    assign warm_rst = cur_q.warm;
endmodule

// File: rtl/fn_pwr_wake.sv
module fn_pwr_wake
    import fn_pwr_pkg::*;
(
    input  logic clk,
    input  logic aon_rst_n,
    input  logic wr_lane,
    input  logic wr_en,
    input  logic wr_clr,
    input  logic wake,
    output logic en,
    output logic sts,
    output logic pme
);
    wake_regs_t cur_q, nxt_d;

    // Sticky status: a wake event in the same cycle wins over a clear.
    always_comb begin
        nxt_d = cur_q;
        if (wr_lane) begin
            nxt_d.en = wr_en;
            if (wr_clr) nxt_d.sts = 1'b0;
        end
        if (wake) nxt_d.sts = 1'b1;
    end

    always_ff @(posedge clk or negedge aon_rst_n) begin
        if (!aon_rst_n) begin
            cur_q <= '{en: 1'b0, sts: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign en  = cur_q.en;
    assign sts = cur_q.sts;
    assign pme = cur_q.en & cur_q.sts;
endmodule

// File: rtl/fn_pwr_gate.sv
module fn_pwr_gate
    import fn_pwr_pkg::*;
(
    input  logic [PS_W-1:0] ps,
    input  logic            irq_in,
    output logic            irq_out,
    output logic            mem_en
);
    logic full_pwr;

    always_comb begin
        full_pwr = (ps == PS_FULL);
        irq_out  = irq_in & full_pwr;
        mem_en   = full_pwr;
    end
endmodule

// File: rtl/fn_pwr_ctl.sv
module fn_pwr_ctl
    import fn_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_main_n,
    input  logic              rst_aon_n,
    input  logic              cfg_wr,
    input  logic [LANES-1:0]  cfg_be,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  reg_value,
    input  logic              wake_evt,
    input  logic              irq_req,
    output logic              irq_out,
    output logic              mem_dec_en,
    output logic              pme_out,
    output logic              warm_rst
);
    localparam int PS_LANE   = PS_LSB / LANE_W;
    localparam int WAKE_LANE = EN_BIT / LANE_W;

    logic [LANES-1:0] lane_wr;
    logic [PS_W-1:0]  ps;
    logic             wake_en;
    logic             wake_sts;
    logic             unused_wdata;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr[g] = cfg_wr & cfg_be[g];
    end

    assign unused_wdata = ^{cfg_wdata[STS_BIT-1:EN_BIT+1], cfg_wdata[EN_BIT-1:PS_LSB+PS_W]};

    fn_pwr_state u_state (
        .clk      (clk),
        .rst_n    (rst_main_n),
        .wr_lane  (lane_wr[PS_LANE]),
        .wr_ps    (cfg_wdata[PS_LSB +: PS_W]),
        .ps       (ps),
        .warm_rst (warm_rst)
    );

    fn_pwr_wake u_wake (
        .clk       (clk),
        .aon_rst_n (rst_aon_n),
        .wr_lane   (lane_wr[WAKE_LANE]),
        .wr_en     (cfg_wdata[EN_BIT]),
        .wr_clr    (cfg_wdata[STS_BIT]),
        .wake      (wake_evt),
        .en        (wake_en),
        .sts       (wake_sts),
        .pme       (pme_out)
    );

    fn_pwr_gate u_gate (
        .ps      (ps),
        .irq_in  (irq_req),
        .irq_out (irq_out),
        .mem_en  (mem_dec_en)
    );

    always_comb begin
        reg_value                   = '0;
        reg_value[PS_LSB +: PS_W]   = ps;
        reg_value[EN_BIT]           = wake_en;
        reg_value[STS_BIT]          = wake_sts;
    end
endmodule

// File: rtl/fn_pwr_ctl_chk.sv
module fn_pwr_ctl_chk (
    input logic        clk,
    input logic        rst_main_n,
    input logic        rst_aon_n,
    input logic [15:0] reg_value,
    input logic        wake_evt,
    input logic        irq_out,
    input logic        mem_dec_en,
    input logic        pme_out,
    input logic        warm_rst
);
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_main_n || !rst_aon_n)
        (reg_value[1:0] == 2'b00 || reg_value[1:0] == 2'b11)); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_main_n || !rst_aon_n)
        (reg_value[1:0] != 2'b00) |-> !irq_out); // R5
    AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_main_n || !rst_aon_n)
        (reg_value[1:0] != 2'b00) |-> !mem_dec_en); // R6
    AST_WARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_main_n || !rst_aon_n)
        warm_rst |=> !warm_rst); // R7
    AST_WARM_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_main_n || !rst_aon_n)
        $rose(warm_rst) |-> (reg_value[1:0] == 2'b00 && $past(reg_value[1:0]) == 2'b11)); // R7
    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_main_n || !rst_aon_n)
        wake_evt |=> reg_value[15]); // R9
    AST_PME_BOTH: assert property (@(posedge clk) disable iff (!rst_main_n || !rst_aon_n)
        pme_out == (reg_value[15] & reg_value[8])); // R10
endmodule

bind fn_pwr_ctl fn_pwr_ctl_chk u_chk (
    .clk        (clk),
    .rst_main_n (rst_main_n),
    .rst_aon_n  (rst_aon_n),
    .reg_value  (reg_value),
    .wake_evt   (wake_evt),
    .irq_out    (irq_out),
    .mem_dec_en (mem_dec_en),
    .pme_out    (pme_out),
    .warm_rst   (warm_rst)
);

// File: tb/fn_pwr_ctl_tb.sv
module fn_pwr_ctl_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_main_n = 1'b1;
    logic        rst_aon_n = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_be = 2'b00;
    logic [15:0] cfg_wdata = 16'h0000;
    logic [15:0] reg_value;
    logic        wake_evt = 1'b0;
    logic        irq_req = 1'b0;
    logic        irq_out, mem_dec_en, pme_out, warm_rst;

    always #(CLK_P/2) clk = ~clk;

    fn_pwr_ctl u_dut (
        .clk(clk), .rst_main_n(rst_main_n), .rst_aon_n(rst_aon_n),
        .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .reg_value(reg_value), .wake_evt(wake_evt), .irq_req(irq_req),
        .irq_out(irq_out), .mem_dec_en(mem_dec_en), .pme_out(pme_out),
        .warm_rst(warm_rst)
    );

    typedef struct {
        string       tag;
        logic [15:0] val;
        logic        irq;
        logic        mem;
        logic        pme;
        logic        warm;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model of the requirements, in bench terms.
    logic [1:0] m_ps = 2'b00;
    logic       m_en = 1'b0, m_sts = 1'b0, m_warm = 1'b0;

    function automatic void push(string tag);
        exp_t e;
        e.tag  = tag;
        e.val  = {m_sts, 6'b0, m_en, 6'b0, m_ps};
        e.irq  = irq_req & (m_ps == 2'b00);
        e.mem  = (m_ps == 2'b00);
        e.pme  = m_en & m_sts;
        e.warm = m_warm;
        q.push_back(e);
    endfunction

    task automatic step(input logic wr, input logic [1:0] be, input logic [15:0] wd,
                        input logic wk, input logic irq, input string tag);
        @(negedge clk);
        cfg_wr = wr; cfg_be = be; cfg_wdata = wd; wake_evt = wk; irq_req = irq;
        @(posedge clk);
        m_warm = 1'b0;
        if (wr && be[0] && (wd[1:0] == 2'b00 || wd[1:0] == 2'b11)) begin
            m_warm = (m_ps == 2'b11) && (wd[1:0] == 2'b00);
            m_ps   = wd[1:0];
        end
        if (wr && be[1]) begin
            m_en = wd[8];
            if (wd[15]) m_sts = 1'b0;
        end
        if (wk) m_sts = 1'b1;
        #1;
        push(tag);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 2'b00; wake_evt = 1'b0;
    endtask

    task automatic do_reset(input logic main_r, input logic aon_r, input string tag);
        @(negedge clk);
        rst_main_n = !main_r; rst_aon_n = !aon_r;
        @(posedge clk);
        if (main_r) begin m_ps = 2'b00; m_warm = 1'b0; end
        if (aon_r)  begin m_en = 1'b0; m_sts = 1'b0; end
        #1;
        push(tag);
        @(negedge clk);
        rst_main_n = 1'b1; rst_aon_n = 1'b1;
    endtask

    // Monitor: compares the design against queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (reg_value !== e.val || irq_out !== e.irq || mem_dec_en !== e.mem ||
                    pme_out !== e.pme || warm_rst !== e.warm) begin
                    errors++;
                    $display("FAIL %s: got reg=%h irq=%b mem=%b pme=%b warm=%b exp reg=%h irq=%b mem=%b pme=%b warm=%b",
                             e.tag, reg_value, irq_out, mem_dec_en, pme_out, warm_rst,
                             e.val, e.irq, e.mem, e.pme, e.warm);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1, 1'b1, "R1 reset state");
        step(1'b0, 2'b00, 16'h0000, 1'b0, 1'b1, "R5 irq passes in full power");
        step(1'b1, 2'b01, 16'h0003, 1'b0, 1'b0, "R2 R6 enter off state");
        step(1'b0, 2'b00, 16'h0000, 1'b0, 1'b1, "R5 irq blocked in off");
        step(1'b1, 2'b01, 16'h0001, 1'b0, 1'b0, "R3 code 01 dropped");
        step(1'b1, 2'b01, 16'h0002, 1'b0, 1'b0, "R3 code 10 dropped");
        step(1'b1, 2'b10, 16'h0000, 1'b0, 1'b0, "R4 high lane keeps state");
        step(1'b1, 2'b01, 16'h0000, 1'b0, 1'b0, "R7 warm pulse on off to full");
        step(1'b0, 2'b00, 16'h0000, 1'b0, 1'b1, "R7 pulse ends, R5 irq passes");
        step(1'b1, 2'b01, 16'h0000, 1'b0, 1'b0, "R7 no pulse full to full");
        step(1'b0, 2'b00, 16'h0000, 1'b1, 1'b0, "R8 wake sets status with enable low");
        step(1'b1, 2'b10, 16'h0100, 1'b0, 1'b0, "R10 enable with status gives wake out");
        step(1'b1, 2'b01, 16'h8003, 1'b0, 1'b0, "R4 low lane keeps wake bits");
        step(1'b1, 2'b11, 16'h8103, 1'b1, 1'b0, "R9 wake beats clear");
        step(1'b1, 2'b11, 16'h8100, 1'b0, 1'b0, "R8 R7 clear status, leave off");
        step(1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, "R7 pulse single cycle");
        step(1'b1, 2'b11, 16'h7EFF, 1'b0, 1'b0, "R11 reserved bits read zero");
        step(1'b0, 2'b00, 16'h0000, 1'b1, 1'b0, "R8 set status again");
        step(1'b1, 2'b10, 16'h0100, 1'b0, 1'b0, "R8 write 0 keeps status");
        do_reset(1'b1, 1'b0, "R12 main reset keeps wake bits");
        step(1'b0, 2'b00, 16'h0000, 1'b0, 1'b1, "R12 after main reset");
        do_reset(1'b0, 1'b1, "R12 always-on reset clears wake bits");
        step(1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, "R1 idle after resets");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule